// File: doc/BRIEF.md
# FIFO Read Controller with Retransmit

This block is the read side of a synchronous FIFO that can replay its contents. Each enabled read takes the word at the read pointer from the storage array and loads it into a registered output. The read pointer then advances. When the active-low replay input is low at a read clock edge, the read pointer returns to storage location zero, so everything written since reset can be read again, as many times as needed.

A latency mode is captured while master reset is asserted and then held. In zero-latency mode the word at location zero reaches the output register on the same edge that sees the replay request. In normal-latency mode that edge only rewinds the pointer, and the first replayed word comes out on the next enabled read. The write pointer comes in from the write side, already in the read clock domain. The block always shows the difference between the two pointers as the number of words left to read, including right after a rewind.

Top module: `fifo_rt_read_ctrl`

## Requirements
- R1: When `rt_n` is low at a rising clock edge (reset low), the read pointer rewinds to storage location zero, and `mem_raddr` shows 0 during that cycle.
- R2: `lat_mode_in` is captured on every edge where `rst` is high: 0 selects zero-latency replay and 1 selects normal-latency replay. Changes to `lat_mode_in` while `rst` is low have no effect.
- R3: In zero-latency mode, if `wr_ptr` is nonzero, the replay edge loads the word at location 0 into `dout` and leaves the read pointer at 1, so `word_count` becomes `wr_ptr` minus 1.
- R4: In normal-latency mode, `dout` keeps its value on the replay edge and the pointer becomes 0. The next enabled read then delivers the word at location 0.
- R5: `rd_en` has no effect on an edge where `rt_n` is low.
- R6: With `rt_n` high, `rd_en` high and `word_count` nonzero, an edge loads the word at the read pointer into `dout` and advances the pointer by one.
- R7: A read request while `word_count` is 0 is ignored: `dout` and the pointer stay unchanged.
- R8: `word_count` equals `wr_ptr` minus the read pointer modulo 2^(ADDR_W+1), at all times, including right after a rewind.
- R9: An edge with `rst` high clears the read pointer and `dout` to zero.
- R10: In zero-latency mode with `wr_ptr` equal to 0, a replay rewinds the pointer and leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge active |
| rst | input | 1 | Master reset, synchronous, active high |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Replay request, active low |
| lat_mode_in | input | 1 | Latency mode, captured during reset (0 zero-latency, 1 normal) |
| wr_ptr | input | ADDR_W+1 | Write pointer from the write side, with wrap bit |
| mem_raddr | output | ADDR_W | Read address to the storage array |
| mem_rdata | input | DATA_W | Storage array data at `mem_raddr`, combinational |
| dout | output | DATA_W | Registered output word |
| word_count | output | ADDR_W+1 | Words still to be read |

## Verification
Some rules are checked on every cycle: the zero address during a replay, the held output in normal-latency mode and with an empty zero-latency replay, the reloaded output and count in zero-latency mode, the count after a normal rewind, the quiet empty read, the reset clear and the frozen mode. Other behaviour needs the bench's scenarios. Examples are the exact order of replayed words over several passes, the delayed first replayed word in normal latency, and proof that a mode pin toggled after reset changes nothing. Those depend on known storage contents, so the bench shows them.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    // operation chosen for one read clock edge
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_READ    = 2'd1,
        OP_RT_HOLD = 2'd2,
        OP_RT_LOAD = 2'd3
    } rd_op_e;

    // replay latency captured at reset
    typedef enum logic {
        LAT_ZERO   = 1'b0,
        LAT_NORMAL = 1'b1
    } rt_lat_e;

    typedef struct packed {
        rd_op_e op;
        logic   rewind;
        logic   load;
    } rd_ctl_t;

    function automatic logic op_is_rewind(rd_op_e op);
        return (op == OP_RT_HOLD) || (op == OP_RT_LOAD);
    endfunction

    function automatic logic op_loads_out(rd_op_e op);
        return (op == OP_READ) || (op == OP_RT_LOAD);
    endfunction

    function automatic rd_ctl_t make_ctl(rd_op_e op);
        rd_ctl_t c;
        c.op     = op;
        c.rewind = op_is_rewind(op);
        c.load   = op_loads_out(op);
        return c;
    endfunction

endpackage

// File: rtl/rt_mode_latch.sv
module rt_mode_latch
    import fifo_rt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    lat_mode_in,
    output rt_lat_e mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= lat_mode_in ? LAT_NORMAL : LAT_ZERO;
        end
    end
endmodule

// File: rtl/rt_op_decode.sv
module rt_op_decode
    import fifo_rt_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  rt_lat_e          mode,
    input  logic             rt_n,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] word_count,
    output rd_ctl_t          ctl
);
    logic have_data;
    logic have_written;

    assign have_data    = (word_count != '0);
    assign have_written = (wr_ptr != '0);

    always_comb begin
        if (!rt_n) begin
            // replay wins over read; read enable is dropped on this edge
            if (mode == LAT_ZERO && have_written) begin
                ctl = make_ctl(OP_RT_LOAD);
            end else begin
                ctl = make_ctl(OP_RT_HOLD);
            end
        end else if (rd_en && have_data) begin
            ctl = make_ctl(OP_READ);
        end else begin
            ctl = make_ctl(OP_IDLE);
        end
    end
endmodule

// File: rtl/rt_read_ptr.sv
module rt_read_ptr
    import fifo_rt_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_ctl_t           ctl,
    input  logic [PTR_W-1:0]  wr_ptr,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PTR_W-1:0]  word_count
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] rd_ptr_nxt;

    always_comb begin
        unique case (ctl.op)
            OP_READ:    rd_ptr_nxt = rd_ptr + PTR_ONE;
            OP_RT_HOLD: rd_ptr_nxt = '0;
            OP_RT_LOAD: rd_ptr_nxt = PTR_ONE;
            default:    rd_ptr_nxt = rd_ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
        end else begin
            rd_ptr <= rd_ptr_nxt;
        end
    end

    // a replay edge addresses location zero so zero latency can load it
    assign mem_raddr  = ctl.rewind ? '0 : rd_ptr[ADDR_W-1:0];
    assign word_count = wr_ptr - rd_ptr;
endmodule

// File: rtl/rt_out_reg.sv
module rt_out_reg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/fifo_rt_read_ctrl.sv
module fifo_rt_read_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rt_n,
    input  logic              lat_mode_in,
    input  logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout,
    output logic [ADDR_W:0]   word_count
);
    localparam int PTR_W = ADDR_W + 1;

    rt_lat_e mode_q;
    rd_ctl_t ctl;

    rt_mode_latch u_mode (
        .clk         (clk),
        .rst         (rst),
        .lat_mode_in (lat_mode_in),
        .mode        (mode_q)
    );

    rt_op_decode #(.PTR_W(PTR_W)) u_dec (
        .mode       (mode_q),
        .rt_n       (rt_n),
        .rd_en      (rd_en),
        .wr_ptr     (wr_ptr),
        .word_count (word_count),
        .ctl        (ctl)
    );

    rt_read_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .wr_ptr     (wr_ptr),
        .mem_raddr  (mem_raddr),
        .word_count (word_count)
    );

    rt_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .din  (mem_rdata),
        .dout (dout)
    );
endmodule

// File: rtl/fifo_rt_read_ctrl_chk.sv
module fifo_rt_read_ctrl_chk
    import fifo_rt_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rt_n,
    input logic [ADDR_W:0]   wr_ptr,
    input logic [ADDR_W-1:0] mem_raddr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] dout,
    input logic [ADDR_W:0]   word_count,
    input rt_lat_e           mode_q
);
    localparam logic [ADDR_W:0] ONE = (ADDR_W + 1)'(1);

    assert_replay_addr_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !rt_n |-> mem_raddr == '0);

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    assert_zero_lat_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!rt_n && mode_q == LAT_ZERO && wr_ptr != '0)
        |=> (dout == $past(mem_rdata)) && (word_count == wr_ptr - ONE));

    assert_normal_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!rt_n && mode_q == LAT_NORMAL) |=> $stable(dout));

    assert_rewind_count_R8: assert property (@(posedge clk) disable iff (rst)
        (!rt_n && mode_q == LAT_NORMAL) |=> word_count == wr_ptr);

    assert_empty_read_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (rt_n && rd_en && word_count == '0) |=> $stable(dout));

    assert_zero_lat_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (!rt_n && mode_q == LAT_ZERO && wr_ptr == '0) |=> $stable(dout));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> dout == '0);
endmodule

bind fifo_rt_read_ctrl fifo_rt_read_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rt_n       (rt_n),
    .wr_ptr     (wr_ptr),
    .mem_raddr  (mem_raddr),
    .mem_rdata  (mem_rdata),
    .dout       (dout),
    .word_count (word_count),
    .mode_q     (mode_q)
);

// File: tb/test_fifo_rt_read_ctrl.sv
module test_fifo_rt_read_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 36;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic       rd;
        logic       rt_n;
        logic [3:0] idx;
        logic [4:0] cnt;
    } vec_t;

    // zero-latency run with six words stored; dout expected = word_at(idx)
    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 4'd0, 5'd5},   // R6 read
        '{1'b1, 1'b1, 4'd1, 5'd4},   // R6
        '{1'b0, 1'b1, 4'd1, 5'd4},   // idle hold
        '{1'b1, 1'b1, 4'd2, 5'd3},   // R6
        '{1'b1, 1'b0, 4'd0, 5'd5},   // R3 R5 replay with read high
        '{1'b1, 1'b1, 4'd1, 5'd4},
        '{1'b1, 1'b1, 4'd2, 5'd3},
        '{1'b1, 1'b1, 4'd3, 5'd2},
        '{1'b1, 1'b1, 4'd4, 5'd1},
        '{1'b1, 1'b1, 4'd5, 5'd0},
        '{1'b1, 1'b1, 4'd5, 5'd0},   // R7 empty read
        '{1'b0, 1'b0, 4'd0, 5'd5},   // R3 replay after drain
        '{1'b1, 1'b0, 4'd0, 5'd5},   // R1 back-to-back replay
        '{1'b1, 1'b1, 4'd1, 5'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          rt_n = 1'b1;
    logic          lat_mode_in = 1'b0;
    logic [AW:0]   wr_ptr = '0;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dout;
    logic [AW:0]   word_count;
    logic [DW-1:0] mem [DEPTH];

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] word_at(int i);
        return 36'h9_0000_0000 | 36'(i * 37 + 11);
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = word_at(i);
    end

    assign mem_rdata = mem[mem_raddr];

    fifo_rt_read_ctrl #(.DATA_W(DW), .ADDR_W(AW)) i_fifo_rt_read_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .rt_n        (rt_n),
        .lat_mode_in (lat_mode_in),
        .wr_ptr      (wr_ptr),
        .mem_raddr   (mem_raddr),
        .mem_rdata   (mem_rdata),
        .dout        (dout),
        .word_count  (word_count)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; leaves control idle after one rising edge
    task automatic apply(logic rd, logic rtn);
        rd_en = rd;
        rt_n  = rtn;
        @(negedge clk);
        rd_en = 1'b0;
        rt_n  = 1'b1;
    endtask

    task automatic do_reset(logic mode);
        rst = 1'b1;
        lat_mode_in = mode;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        lat_mode_in = ~mode;   // R2: must be ignored from here on
    endtask

    initial begin
        @(negedge clk);
        wr_ptr = 5'd6;
        do_reset(1'b0);
        chk("R9 reset dout", 64'(dout), 64'(0));
        chk("R8 reset count", 64'(word_count), 64'(6));

        // vector walk, zero-latency mode
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v].rd, VEC[v].rt_n);
            chk($sformatf("R6 vec%0d dout", v), 64'(dout), 64'(word_at(int'(VEC[v].idx))));
            chk($sformatf("R8 vec%0d count", v), 64'(word_count), 64'(VEC[v].cnt));
        end

        // R1: address is zero while replay is requested
        rt_n = 1'b0;
        #1;
        chk("R1 raddr during replay", 64'(mem_raddr), 64'(0));
        @(negedge clk);
        rt_n = 1'b1;
        chk("R3 replay load", 64'(dout), 64'(word_at(0)));

        // normal-latency mode
        do_reset(1'b1);
        chk("R9 reset after run dout", 64'(dout), 64'(0));
        chk("R9 reset after run count", 64'(word_count), 64'(6));
        apply(1'b1, 1'b1);
        apply(1'b1, 1'b1);
        apply(1'b1, 1'b1);
        chk("R6 normal read 3", 64'(dout), 64'(word_at(2)));
        apply(1'b1, 1'b0);
        chk("R4 hold on replay", 64'(dout), 64'(word_at(2)));
        chk("R8 count after rewind", 64'(word_count), 64'(6));
        apply(1'b0, 1'b1);
        chk("R4 idle after replay", 64'(dout), 64'(word_at(2)));
        apply(1'b1, 1'b1);
        chk("R4 first replayed word", 64'(dout), 64'(word_at(0)));
        chk("R2 mode kept normal count", 64'(word_count), 64'(5));

        // zero-latency with nothing written
        wr_ptr = '0;
        do_reset(1'b0);
        apply(1'b1, 1'b1);
        chk("R7 read on empty", 64'(dout), 64'(0));
        apply(1'b0, 1'b0);
        chk("R10 empty replay holds", 64'(dout), 64'(0));
        chk("R10 empty replay count", 64'(word_count), 64'(0));
        wr_ptr = 5'd2;
        #1;
        chk("R8 count follows wr_ptr", 64'(word_count), 64'(2));
        @(negedge clk);
        apply(1'b1, 1'b1);
        chk("R6 read after write", 64'(dout), 64'(word_at(0)));
        apply(1'b0, 1'b0);
        chk("R2 zero mode kept", 64'(dout), 64'(word_at(0)));
        chk("R3 count after zero replay", 64'(word_count), 64'(1));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule